// File: doc/BRIEF.md
# Atomic Reservation Monitor

This block holds one memory reservation for atomic read-modify-write sequences. A reserving load records the effective address it touched and the width of the access: byte, halfword, word or doubleword. A later conditional store is checked against that record. The store may write memory only if a reservation is held, the address matches exactly and the access width is the same. The result is given as a 4-bit condition field. Every conditional store clears the reservation, whether it succeeds or fails.

The block sits next to the load/store unit. The unit presents one operation per cycle on a strobe. Each operation carries a kind, a size code, a 64-bit effective address and the current summary-overflow bit. The block returns a store-enable and the condition field in the same cycle as the operation. The reservation itself changes at the next clock edge. Memory and coherence snooping are outside the block. A snoop or context-switch path drops the reservation through an invalidate input.

Top module: `atomic_resv_monitor`

## Requirements
- R1: While reset is asserted, and after it is released, no reservation is held: a conditional store issued directly after reset fails.
- R2: A reserving operation (strobe high, kind 0) records its address and size. A following conditional store (kind 1) with the same address and size succeeds: store_en_o is 1 in that cycle.
- R3: During a conditional store, cr0_o[3:2] is 0, cr0_o[1] is 1 exactly on success, and cr0_o[0] equals so_i. In any cycle without a conditional store, cr0_o and store_en_o are 0.
- R4: A conditional store whose address differs from the reserved address in any bit fails.
- R5: Size codes are 0 byte, 1 halfword, 2 word and 3 doubleword, and all four are accepted on both sides. A conditional store whose size code differs from the reserving one fails, even when the address matches.
- R6: Every conditional store clears the reservation, so the next conditional store fails unless a new reservation is made in between.
- R7: A new reserving operation replaces any reservation already held.
- R8: inval_i clears the reservation at the next edge and wins over a reserving operation in the same cycle. A conditional store in the same cycle as inval_i is judged on the reservation held before that edge.
- R9: store_en_o is 1 only for a successful conditional store, never for a failed one.
- R10: With op_valid_i low, the other operation inputs are ignored and the reservation is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_valid_i | input | 1 | Operation strobe |
| op_kind_i | input | 1 | 0 reserving load, 1 conditional store |
| op_size_i | input | 2 | Access size code |
| op_addr_i | input | 64 | Effective address |
| so_i | input | 1 | Summary-overflow bit |
| inval_i | input | 1 | Drop the reservation |
| store_en_o | output | 1 | Conditional store may write memory |
| cr0_o | output | 4 | Condition field for the conditional store |

## Verification
Both store_en_o and cr0_o are combinational in the operation's own cycle. The bench therefore drives each operation at the falling edge and samples the outputs 3 ns later, before the rising edge. The reservation changes only at the rising edge. The bench's reference model is updated after sampling, so its effect is first seen by the next operation. This applies to a clear by a conditional store or by an invalidate, and to a replacement by a new reserving load.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;
  localparam int unsigned NUM_SIZES = 4;
  localparam int unsigned SIZE_W    = $clog2(NUM_SIZES);

  typedef enum logic {
    OP_RESERVE = 1'b0,
    OP_COND    = 1'b1
  } op_kind_e;

  localparam logic [1:0] CR0_HIT_BIT = 2'd1;
endpackage

// File: rtl/lrsc_len_dec.sv
// Size code -> one-hot length; the one-hot value equals the byte count.
module lrsc_len_dec #(
  parameter int unsigned NUM_SIZES = 4,
  localparam int unsigned SIZE_W = $clog2(NUM_SIZES)
) (
  input  logic [SIZE_W-1:0]    size_i,
  output logic [NUM_SIZES-1:0] len_o
);
  for (genvar i = 0; i < NUM_SIZES; i++) begin : g_len
    assign len_o[i] = (size_i == SIZE_W'(i));
  end
endmodule

// File: rtl/lrsc_addr_cmp.sv
// Chunked equality compare to keep each AND tree short.
module lrsc_addr_cmp #(
  parameter int unsigned ADDR_W  = 64,
  parameter int unsigned CHUNK_W = 16,
  localparam int unsigned NUM_CHUNKS = (ADDR_W + CHUNK_W - 1) / CHUNK_W,
  localparam int unsigned PAD_W = NUM_CHUNKS * CHUNK_W
) (
  input  logic [ADDR_W-1:0] a_i,
  input  logic [ADDR_W-1:0] b_i,
  output logic              eq_o
);
  logic [PAD_W-1:0]      a_pad, b_pad;
  logic [NUM_CHUNKS-1:0] chunk_eq;

  assign a_pad = PAD_W'(a_i);
  assign b_pad = PAD_W'(b_i);

  for (genvar c = 0; c < NUM_CHUNKS; c++) begin : g_chunk
    assign chunk_eq[c] = (a_pad[c*CHUNK_W +: CHUNK_W] == b_pad[c*CHUNK_W +: CHUNK_W]);
  end

  assign eq_o = &chunk_eq;
endmodule

// File: rtl/lrsc_resv_reg.sv
// Reservation state; clear has priority over set.
module lrsc_resv_reg #(
  parameter int unsigned ADDR_W    = 64,
  parameter int unsigned NUM_SIZES = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 set_i,
  input  logic                 clr_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [NUM_SIZES-1:0] len_i,
  output logic                 valid_o,
  output logic [ADDR_W-1:0]    addr_o,
  output logic [NUM_SIZES-1:0] len_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      addr_o  <= '0;
      len_o   <= '0;
    end else if (clr_i) begin
      valid_o <= 1'b0;
    end else if (set_i) begin
      valid_o <= 1'b1;
      addr_o  <= addr_i;
      len_o   <= len_i;
    end
  end
endmodule

// File: rtl/atomic_resv_monitor.sv
module atomic_resv_monitor
  import lrsc_pkg::*;
#(
  parameter int unsigned ADDR_W  = 64,
  parameter int unsigned CHUNK_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              op_valid_i,
  input  logic              op_kind_i,
  input  logic [SIZE_W-1:0] op_size_i,
  input  logic [ADDR_W-1:0] op_addr_i,
  input  logic              so_i,
  input  logic              inval_i,
  output logic              store_en_o,
  output logic [3:0]        cr0_o
);
  logic                 is_resv, is_cond;
  logic [NUM_SIZES-1:0] op_len, rsv_len;
  logic [ADDR_W-1:0]    rsv_addr;
  logic                 rsv_valid, addr_eq, hit;

  assign is_resv = op_valid_i && (op_kind_e'(op_kind_i) == OP_RESERVE);
  assign is_cond = op_valid_i && (op_kind_e'(op_kind_i) == OP_COND);

  lrsc_len_dec #(.NUM_SIZES(NUM_SIZES)) i_len_dec (
    .size_i (op_size_i),
    .len_o  (op_len)
  );

  lrsc_resv_reg #(.ADDR_W(ADDR_W), .NUM_SIZES(NUM_SIZES)) i_resv_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (is_resv),
    .clr_i   (inval_i || is_cond),
    .addr_i  (op_addr_i),
    .len_i   (op_len),
    .valid_o (rsv_valid),
    .addr_o  (rsv_addr),
    .len_o   (rsv_len)
  );

  lrsc_addr_cmp #(.ADDR_W(ADDR_W), .CHUNK_W(CHUNK_W)) i_addr_cmp (
    .a_i  (op_addr_i),
    .b_i  (rsv_addr),
    .eq_o (addr_eq)
  );

  assign hit = rsv_valid && addr_eq && (rsv_len == op_len);

  always_comb begin
    store_en_o = 1'b0;
    cr0_o      = 4'b0000;
    if (is_cond) begin
      store_en_o          = hit;
      cr0_o[CR0_HIT_BIT]  = hit;
      cr0_o[0]            = so_i;
    end
  end
endmodule

// File: rtl/lrsc_checker.sv
module lrsc_checker #(
  parameter int unsigned ADDR_W = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              op_valid_i,
  input logic              op_kind_i,
  input logic [1:0]        op_size_i,
  input logic [ADDR_W-1:0] op_addr_i,
  input logic              so_i,
  input logic              inval_i,
  input logic              store_en_o,
  input logic [3:0]        cr0_o
);
  // R9: store only during a conditional store
  a_r9_store_only_cond: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_en_o |-> (op_valid_i && op_kind_i));

  // R3: field layout during a conditional store
  a_r3_cr0_layout: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_kind_i) |-> (cr0_o[3:2] == 2'b00 && cr0_o[0] == so_i && cr0_o[1] == store_en_o));

  // R3: quiet outputs without a conditional store
  a_r3_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(op_valid_i && op_kind_i) |-> (cr0_o == 4'b0000 && !store_en_o));

  // R6: no success right after any conditional store
  a_r6_cond_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_kind_i) |=> !store_en_o);

  // R8: no success right after invalidate
  a_r8_inval_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inval_i |=> !store_en_o);
endmodule

bind atomic_resv_monitor lrsc_checker #(.ADDR_W(ADDR_W)) i_lrsc_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .op_valid_i (op_valid_i),
  .op_kind_i  (op_kind_i),
  .op_size_i  (op_size_i),
  .op_addr_i  (op_addr_i),
  .so_i       (so_i),
  .inval_i    (inval_i),
  .store_en_o (store_en_o),
  .cr0_o      (cr0_o)
);

// File: tb/test_atomic_resv_monitor.sv
`timescale 1ns/1ps
module test_atomic_resv_monitor;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        op_valid_i = 1'b0;
  logic        op_kind_i = 1'b0;
  logic [1:0]  op_size_i = 2'd0;
  logic [63:0] op_addr_i = '0;
  logic        so_i = 1'b0;
  logic        inval_i = 1'b0;
  logic        store_en_o;
  logic [3:0]  cr0_o;

  int n_checks = 0;
  int n_fail   = 0;

  bit          m_valid = 1'b0;
  logic [63:0] m_addr  = '0;
  logic [1:0]  m_size  = '0;

  always #5 clk_i = ~clk_i;

  atomic_resv_monitor i_atomic_resv_monitor (.*);

  function automatic logic [4:0] expect_out(bit v, bit k, logic [1:0] s, logic [63:0] a, bit so);
    bit hit;
    hit = m_valid && (m_size == s) && (m_addr == a);
    if (v && k) return {hit, 2'b00, hit, so};
    return 5'b0;
  endfunction

  task automatic chk(string req, logic [4:0] act, logic [4:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {store_en,cr0} act=%b exp=%b", req, act, exp);
    end
  endtask

  task automatic do_op(string req, bit v, bit k, logic [1:0] s, logic [63:0] a, bit so, bit inv);
    logic [4:0] exp;
    @(negedge clk_i);
    op_valid_i = v; op_kind_i = k; op_size_i = s; op_addr_i = a; so_i = so; inval_i = inv;
    #3;
    exp = expect_out(v, k, s, a, so);
    chk(req, {store_en_o, cr0_o}, exp);
    if (inv) m_valid = 1'b0;
    else if (v && !k) begin m_valid = 1'b1; m_addr = a; m_size = s; end
    if (v && k) m_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    #2;
    op_valid_i = 1'b1; op_kind_i = 1'b1; so_i = 1'b0;
    #1;
    chk("R1 in reset", {store_en_o, cr0_o}, 5'b0_0000);
    op_valid_i = 1'b0; op_kind_i = 1'b0;
    #20 rst_ni = 1'b1;

    do_op("R1 cond after reset", 1, 1, 2, 64'h100, 1, 0);
    do_op("R2 reserve", 1, 0, 2, 64'h100, 0, 0);
    do_op("R2 R9 cond hit", 1, 1, 2, 64'h100, 0, 0);
    do_op("R6 second cond", 1, 1, 2, 64'h100, 0, 0);
    do_op("R5 reserve dw", 1, 0, 3, 64'h200, 0, 0);
    do_op("R5 size mismatch", 1, 1, 2, 64'h200, 1, 0);
    do_op("R6 after failed cond", 1, 1, 3, 64'h200, 0, 0);
    do_op("R4 reserve byte", 1, 0, 0, 64'h300, 0, 0);
    do_op("R4 addr mismatch", 1, 1, 0, 64'h308, 0, 0);
    do_op("R4 reserve high", 1, 0, 1, 64'h8000_0000_0000_0040, 0, 0);
    do_op("R4 top bit differs", 1, 1, 1, 64'h0000_0000_0000_0040, 0, 0);
    do_op("R7 reserve A", 1, 0, 2, 64'h400, 0, 0);
    do_op("R7 reserve B", 1, 0, 2, 64'h500, 0, 0);
    do_op("R7 cond on old A", 1, 1, 2, 64'h400, 0, 0);
    do_op("R7 reserve A", 1, 0, 2, 64'h400, 0, 0);
    do_op("R7 reserve B", 1, 0, 3, 64'h500, 0, 0);
    do_op("R7 R3 cond on B so", 1, 1, 3, 64'h500, 1, 0);
    do_op("R8 reserve", 1, 0, 2, 64'h600, 0, 0);
    do_op("R8 invalidate", 0, 0, 0, 64'h0, 0, 1);
    do_op("R8 cond after inval", 1, 1, 2, 64'h600, 0, 0);
    do_op("R8 reserve with inval", 1, 0, 2, 64'h700, 0, 1);
    do_op("R8 cond after clash", 1, 1, 2, 64'h700, 0, 0);
    do_op("R8 reserve", 1, 0, 1, 64'h800, 0, 0);
    do_op("R8 cond with inval", 1, 1, 1, 64'h800, 0, 1);
    do_op("R10 reserve", 1, 0, 3, 64'h900, 0, 0);
    do_op("R10 R3 strobe low", 0, 1, 0, 64'h123, 1, 0);
    do_op("R10 strobe low resv", 0, 0, 1, 64'hA00, 0, 0);
    do_op("R10 cond still held", 1, 1, 3, 64'h900, 0, 0);
    for (int s = 0; s < 4; s++) begin
      do_op("R5 reserve size", 1, 0, 2'(s), 64'hB00 + 64'(s), 0, 0);
      do_op("R5 R2 cond size", 1, 1, 2'(s), 64'hB00 + 64'(s), 1, 0);
    end

    for (int i = 0; i < 3000; i++) begin
      bit v, k, inv, so;
      logic [1:0]  s;
      logic [63:0] a;
      v   = ($urandom % 8) != 0;
      k   = $urandom % 2;
      inv = ($urandom % 12) == 0;
      so  = $urandom % 2;
      s   = 2'($urandom % 4);
      a   = (($urandom % 4) == 0) ? {$urandom, $urandom} : 64'h1000 + 64'(($urandom % 3) * 8);
      if (k && m_valid && ($urandom % 2)) begin a = m_addr; s = m_size; end
      do_op("R2 R9 random", v, k, s, a, so, inv);
    end

    finish_run();
  end
endmodule